// File: doc/BRIEF.md
# ECP Port FIFO with Extended Control Register

This block is the host-facing core of an IEEE 1284 ECP-style parallel port. It holds a 16-byte byte FIFO whose producer and consumer change sides with a direction input. When the direction is host to peripheral, host data writes fill the FIFO and the peripheral side drains it. When the direction is peripheral to host, the peripheral side fills it and host reads drain it. Next to the FIFO sits an 8-bit extended control register. Its upper five bits are host settings: a 3-bit port mode, an error-interrupt mask and a DMA enable. Its lower three bits are status: FIFO empty, FIFO full, and a service bit.

The service bit tells the host that the port needs attention, and it raises a one-cycle interrupt pulse when it gets set. The condition that sets it depends on the settings:

- With DMA enabled, the condition is a terminal-count strobe from the external DMA engine.
- With DMA disabled and the direction host to peripheral, the condition is at least half the FIFO free.
- With DMA disabled and the direction peripheral to host, the condition is at least half the FIFO filled.

While the service bit is set, further events are ignored and the DMA request is withheld. The host re-arms the bit with a dedicated acknowledge strobe. Selecting either of the two plain-PIO modes flushes the FIFO.

Top module: `ecp_fifo_ctl`

## Requirements
- R1: After reset the control byte reads 0x05: mode 000, mask 0, DMA 0, service 1, full 0, empty 1. `irq_pulse` and `dma_go` are 0.
- R2: Control bit 0 is 1 exactly when the FIFO holds no bytes. Bit 1 is 1 exactly when it holds 16 bytes. The two bits are never 1 together.
- R3: A control write (`h_wr`=1, `h_sel`=1) loads the mode into bits 7:5, the error mask into bit 4 and the DMA enable into bit 3, all from `h_wdata`. The values in `h_wdata[2:0]` have no effect on bits 2:0.
- R4: The FIFO returns bytes in arrival order on `fifo_out`. A push while full is dropped, and a pop while empty has no effect.
- R5: With DMA off, `dir_rev`=0 and the service bit at 0, having 8 or more free slots sets the service bit and pulses `irq_pulse` on the next clock edge.
- R6: With DMA off, `dir_rev`=1 and the service bit at 0, holding 8 or more bytes sets the service bit and pulses `irq_pulse` on the next clock edge.
- R7: With DMA on, only `tc_in` is an event. It sets the service bit and pulses `irq_pulse` on the next edge, and FIFO level is then not an event.
- R8: While the service bit is 1 no event produces a pulse. `dma_go` is 1 only when DMA is enabled and the service bit is 0.
- R9: `svc_ack` clears the service bit on the next edge and takes priority over a simultaneous event. A condition that still holds sets the bit again one cycle later.
- R10: A control write selecting mode 000 or 001 empties the FIFO on that edge, and takes priority over a simultaneous push.
- R11: `irq_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rev | input | 1 | 0: host to peripheral, 1: peripheral to host |
| h_wr | input | 1 | Host write strobe |
| h_sel | input | 1 | Host write target: 0 FIFO data, 1 control register |
| h_wdata | input | 8 | Host write byte |
| h_rd | input | 1 | Host FIFO read (pop) strobe, used when `dir_rev`=1 |
| svc_ack | input | 1 | Clears the service bit |
| p_push | input | 1 | Peripheral-side push, used when `dir_rev`=1 |
| p_din | input | 8 | Peripheral-side push byte |
| p_pop | input | 1 | Peripheral-side pop, used when `dir_rev`=0 |
| tc_in | input | 1 | DMA terminal-count strobe |
| fifo_out | output | 8 | Oldest FIFO byte |
| ctl_q | output | 8 | Control register readback |
| irq_pulse | output | 1 | One-cycle service interrupt |
| dma_go | output | 1 | DMA request permission |

## Verification
The assertions check, on every cycle, the properties that hold at any single edge:

- a pulse always leaves the service bit set;
- a pulse needs the service bit to have been clear on the cycle before;
- pulses never come back to back;
- an acknowledge always clears the bit;
- a flushing mode write always leaves the FIFO empty;
- the occupancy never exceeds the depth, and empty and full are never raised together.

The threshold positions in each direction can only be shown by scenarios: where exactly the bit sets when the level passes half in either direction, that terminal count takes over from FIFO level once DMA is enabled, the byte order, and the dropping of a 17th byte. The bench covers these with a queue-based model compared on every clock.

// File: rtl/ecpf_pkg.sv
package ecpf_pkg;

  typedef enum logic [2:0] {
    MODE_PIO_STD  = 3'b000,
    MODE_PIO_NIB  = 3'b001,
    MODE_FIFO_STD = 3'b010,
    MODE_ECP      = 3'b011,
    MODE_EPP      = 3'b100,
    MODE_RSVD     = 3'b101,
    MODE_TEST     = 3'b110,
    MODE_CONFIG   = 3'b111
  } port_mode_e;

  // Modes in which the FIFO is not used and is held empty.
  function automatic logic mode_flushes(input logic [2:0] m);
    return (m == MODE_PIO_STD) || (m == MODE_PIO_NIB);
  endfunction

  function automatic int free_slots(input int depth, input int occ);
    return depth - occ;
  endfunction

  // Service condition: terminal count under DMA, else half-depth level in the active direction.
  function automatic logic svc_event(input logic dma_on, input logic tc,
                                     input logic dir_rev, input int occ,
                                     input int depth);
    if (dma_on) return tc;
    if (dir_rev) return occ >= depth / 2;
    return free_slots(depth, occ) >= depth / 2;
  endfunction

endpackage

// File: rtl/ecpf_fifo.sv
module ecpf_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (occ == '0);
  assign full    = (occ == CW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/ecpf_ctl.sv
module ecpf_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [4:0] wdata_hi,
  output logic [2:0] mode,
  output logic       err_mask,
  output logic       dma_en,
  output logic       flush
);
  import ecpf_pkg::*;

  // Only the writable upper five bits are presented; the lower three never reach here.
  assign flush = wr && mode_flushes(wdata_hi[4:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_PIO_STD;
      err_mask <= 1'b0;
      dma_en   <= 1'b0;
    end else if (wr) begin
      mode     <= wdata_hi[4:2];
      err_mask <= wdata_hi[1];
      dma_en   <= wdata_hi[0];
    end
  end
endmodule

// File: rtl/ecpf_svc.sv
module ecpf_svc #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          tc,
  input  logic          dir_rev,
  input  logic [CW-1:0] occ,
  input  logic          ack,
  output logic          svc,
  output logic          irq,
  output logic          evt
);
  import ecpf_pkg::*;

  assign evt = svc_event(dma_en, tc, dir_rev, int'(occ), DEPTH);

  // Reset with the bit set so nothing fires until the host re-arms it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc <= 1'b1;
      irq <= 1'b0;
    end else if (ack) begin
      svc <= 1'b0;
      irq <= 1'b0;
    end else if (!svc && evt) begin
      svc <= 1'b1;
      irq <= 1'b1;
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ecp_fifo_ctl.sv
module ecp_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rev,
  input  logic          h_wr,
  input  logic          h_sel,
  input  logic [7:0]    h_wdata,
  input  logic          h_rd,
  input  logic          svc_ack,
  input  logic          p_push,
  input  logic [DW-1:0] p_din,
  input  logic          p_pop,
  input  logic          tc_in,
  output logic [DW-1:0] fifo_out,
  output logic [7:0]    ctl_q,
  output logic          irq_pulse,
  output logic          dma_go
);
  logic          push_req, pop_req, ctl_wr, flush_evt;
  logic [DW-1:0] push_data;
  logic [CW-1:0] occ;
  logic          f_empty, f_full;
  logic [2:0]    mode;
  logic          err_mask, dma_en, svc, svc_evt;

  assign ctl_wr    = h_wr && h_sel;
  assign push_req  = dir_rev ? p_push : (h_wr && !h_sel);
  assign push_data = dir_rev ? p_din  : DW'(h_wdata);
  assign pop_req   = dir_rev ? h_rd   : p_pop;

  ecpf_ctl u_ctl (
    .clk, .rst_n, .wr(ctl_wr), .wdata_hi(h_wdata[7:3]),
    .mode, .err_mask, .dma_en, .flush(flush_evt)
  );

  ecpf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk, .rst_n, .push(push_req), .din(push_data), .pop(pop_req),
    .flush(flush_evt), .dout(fifo_out), .occ, .empty(f_empty), .full(f_full)
  );

  ecpf_svc #(.DEPTH(DEPTH)) u_svc (
    .clk, .rst_n, .dma_en, .tc(tc_in), .dir_rev, .occ, .ack(svc_ack),
    .svc, .irq(irq_pulse), .evt(svc_evt)
  );

  assign ctl_q  = {mode, err_mask, dma_en, svc, f_full, f_empty};
  assign dma_go = dma_en && !svc;
endmodule

// File: rtl/ecpf_chk.sv
module ecpf_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ctl_q,
  input logic          irq_pulse,
  input logic          svc_ack,
  input logic          flush_evt,
  input logic [CW-1:0] occ
);
  AST_NO_OVERFLOW:    assert property (@(posedge clk) disable iff (!rst_n) occ <= CW'(DEPTH)); // R4
  AST_FLAGS_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(ctl_q[0] && ctl_q[1])); // R2
  AST_PULSE_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> ctl_q[2]); // R5
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> !$past(ctl_q[2])); // R8
  AST_ACK_CLEARS:     assert property (@(posedge clk) disable iff (!rst_n) svc_ack |=> !ctl_q[2]); // R9
  AST_FLUSH_EMPTIES:  assert property (@(posedge clk) disable iff (!rst_n) flush_evt |=> ctl_q[0]); // R10
  AST_PULSE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |=> !irq_pulse); // R11
endmodule

bind ecp_fifo_ctl ecpf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .irq_pulse(irq_pulse),
  .svc_ack(svc_ack), .flush_evt(flush_evt), .occ(occ)
);

// File: tb/ecp_fifo_ctl_bench.sv
module ecp_fifo_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic dir_rev = 0, h_wr = 0, h_sel = 0, h_rd = 0, svc_ack = 0;
  logic p_push = 0, p_pop = 0, tc_in = 0;
  logic [7:0] h_wdata = 0, p_din = 0, fifo_out, ctl_q;
  logic irq_pulse, dma_go;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ecp_fifo_ctl u_ecp_fifo_ctl (.*);

  // Behavioural reference model
  byte unsigned q[$];
  bit [2:0] m_mode; bit m_mask, m_dma, m_svc = 1, m_irq;
  bit started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_mask = 0; m_dma = 0; m_svc = 1; m_irq = 0;
    end else begin
      int sz; bit cond, push, pop, flush;
      sz = q.size();
      cond = m_dma ? tc_in : (dir_rev ? (sz >= 8) : ((16 - sz) >= 8));
      if (svc_ack) begin m_svc = 0; m_irq = 0; end
      else if (!m_svc && cond) begin m_svc = 1; m_irq = 1; end
      else m_irq = 0;
      push  = dir_rev ? p_push : (h_wr && !h_sel);
      pop   = dir_rev ? h_rd : p_pop;
      flush = h_wr && h_sel && (h_wdata[7:6] == 2'b00);
      if (flush) q.delete();
      else begin
        bit pok, wok;
        pok = pop && sz > 0;
        wok = push && sz < 16;
        if (pok) void'(q.pop_front());
        if (wok) q.push_back(dir_rev ? p_din : h_wdata);
      end
      if (h_wr && h_sel) begin
        m_mode = h_wdata[7:5]; m_mask = h_wdata[4]; m_dma = h_wdata[3];
      end
      started = 1;
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R2 R3 ctl model", ctl_q,
          {m_mode, m_mask, m_dma, m_svc, 1'(q.size() == 16), 1'(q.size() == 0)});
      chk("R11 irq model", 8'(irq_pulse), 8'(m_irq));
      chk("R8 dma_go model", 8'(dma_go), 8'(m_dma && !m_svc));
      if (q.size() > 0) chk("R4 data model", fifo_out, q[0]);
    end
  end

  task automatic step(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic hwrite(bit sel, logic [7:0] d);
    h_wr = 1; h_sel = sel; h_wdata = d; step(); h_wr = 0; h_sel = 0;
  endtask
  task automatic ppush(logic [7:0] d); p_push = 1; p_din = d; step(); p_push = 0; endtask
  task automatic ppop(); p_pop = 1; step(); p_pop = 0; endtask
  task automatic hrd(); h_rd = 1; step(); h_rd = 0; endtask
  task automatic ack(); svc_ack = 1; step(); svc_ack = 0; endtask
  task automatic tcp(); tc_in = 1; step(); tc_in = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; step();
    chk("R1 reset ctl", ctl_q, 8'h05);
    chk("R1 reset irq", 8'(irq_pulse), 8'h0);
    chk("R1 reset dma_go", 8'(dma_go), 8'h0);

    // Host to peripheral, empty FIFO: re-arm, then the free-space event
    ack();
    chk("R9 ack clears", 8'(ctl_q[2]), 8'h0);
    step();
    chk("R5 free>=8 sets svc", 8'(ctl_q[2]), 8'h1);
    chk("R5 pulse", 8'(irq_pulse), 8'h1);
    step();
    chk("R11 pulse single", 8'(irq_pulse), 8'h0);

    // Fill to 9 (7 free), re-arm, then drain one to reach 8 free
    for (int i = 0; i < 9; i++) hwrite(0, 8'h10 + 8'(i));
    chk("R2 not empty", 8'(ctl_q[0]), 8'h0);
    ack(); step();
    chk("R5 below threshold", 8'(ctl_q[2]), 8'h0);
    chk("R4 head", fifo_out, 8'h10);
    ppop();
    chk("R5 event seen next edge", 8'(ctl_q[2]), 8'h0);
    step();
    chk("R5 free==8 sets", 8'(ctl_q[2]), 8'h1);
    chk("R5 pulse at 8 free", 8'(irq_pulse), 8'h1);
    hwrite(1, 8'h20);
    chk("R10 flush nibble", ctl_q, 8'h25);

    // Peripheral to host: fill threshold
    dir_rev = 1;
    hwrite(1, 8'h67);
    chk("R3 low bits ignored", ctl_q, 8'h65);
    ack(); step();
    for (int i = 0; i < 7; i++) ppush(8'hA0 + 8'(i));
    chk("R6 seven held", 8'(ctl_q[2]), 8'h0);
    ppush(8'hA7);
    chk("R6 event seen next edge", 8'(ctl_q[2]), 8'h0);
    step();
    chk("R6 eight held sets", 8'(ctl_q[2]), 8'h1);
    chk("R6 pulse", 8'(irq_pulse), 8'h1);
    chk("R4 order 0", fifo_out, 8'hA0);
    hrd();
    chk("R4 order 1", fifo_out, 8'hA1);

    // Full and overflow
    hwrite(1, 8'h00);
    hwrite(1, 8'h60);
    for (int i = 0; i < 17; i++) ppush(8'(i));
    chk("R2 full", ctl_q, 8'h66);
    for (int i = 0; i < 16; i++) begin
      chk("R4 drain order", fifo_out, 8'(i));
      hrd();
    end
    chk("R4 extra byte dropped", ctl_q, 8'h65);
    hrd();
    chk("R4 pop empty ignored", ctl_q, 8'h65);
    ppush(8'h5A);
    chk("R4 after empty pop", fifo_out, 8'h5A);

    // DMA and terminal count
    hwrite(1, 8'h68);
    chk("R7 dma ctl", ctl_q, 8'h6C);
    chk("R8 dma held by svc", 8'(dma_go), 8'h0);
    ack();
    chk("R8 dma_go armed", 8'(dma_go), 8'h1);
    dir_rev = 0; step(2);
    chk("R7 level not event under DMA", 8'(ctl_q[2]), 8'h0);
    tcp();
    chk("R7 tc sets svc", 8'(ctl_q[2]), 8'h1);
    chk("R7 tc pulse", 8'(irq_pulse), 8'h1);
    chk("R8 dma_go withheld", 8'(dma_go), 8'h0);
    tc_in = 1; svc_ack = 1; step(); svc_ack = 0; tc_in = 0;
    chk("R9 ack beats tc", 8'(ctl_q[2]), 8'h0);
    chk("R9 no pulse on ack", 8'(irq_pulse), 8'h0);
    tcp();
    chk("R7 tc pulse again", 8'(irq_pulse), 8'h1);
    tcp();
    chk("R8 suppressed while set", 8'(irq_pulse), 8'h0);
    hwrite(1, 8'h17);
    chk("R3 mask bit and flush", ctl_q, 8'h15);
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule